// File: doc/BRIEF.md
# Framed Serial Command Register

This block receives eight-bit commands over a three-wire serial link (select, clock, data) and holds the last accepted command in a register whose bits drive eight output-enable lines. Select idles high. A frame begins when select falls. Data is shifted in on each falling serial clock, least significant bit first. The frame ends when select rises. The new command is committed, and takes effect at once, only if exactly eight serial clocks arrived during the frame. Shorter or longer frames leave the command untouched and raise a one-cycle flag that tells the host what went wrong.

The serial clock, select and data pins are brought into the system clock domain through a synchronizer chain, and all edges are detected on the synchronized copies. Each output also has a protection path. A short-circuit flag for that output, combined with the shared overtemperature flag, forces its command bit to zero. This clear wins over a frame that commits in the same cycle. The bit stays off until a later valid frame sets it again. When every command bit is zero, the block reports standby.

Top module: `serial_cmd_reg`

## Requirements
- R1: After reset, all enable outputs are 0, standby is 1, and both frame-error pulses are 0.
- R2: The first data bit of a frame lands in command bit 0 and the eighth in bit 7. Bit i drives enable line i. Lines 0 to 3 are the low-side outputs 1 to 4, and lines 4 to 7 are the high-side outputs 1 to 4.
- R3: A frame commits on the rising edge of select only if exactly eight falling serial clocks occurred while select was low. Before that edge the enables keep their old value.
- R4: A frame with fewer than eight clocks, including none, leaves the command unchanged and gives exactly one system-cycle pulse on the short-frame output.
- R5: A frame with more than eight clocks leaves the command unchanged and gives exactly one system-cycle pulse on the long-frame output. Clocks after the eighth do not move the shift register. The clock counter saturates at nine.
- R6: Serial clocks that arrive while select is high have no effect on the next frame's content.
- R7: Standby is 1 exactly when all eight command bits are 0.
- R8: A command bit is cleared when its short flag and the overtemperature flag are both 1. Either flag alone has no effect.
- R9: If a commit and a protection clear hit the same bit in the same cycle, the bit ends up 0.
- R10: A bit cleared by protection stays 0 after the fault flags drop, until a valid frame sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Serial select, high = idle |
| sclk_i | input | 1 | Serial clock, data taken on falling edge |
| sdat_i | input | 1 | Serial data |
| short_i | input | 8 | Per-output short-circuit flag |
| overtemp_i | input | 1 | Shared overtemperature flag |
| en_o | output | 8 | Output-enable lines (command register) |
| standby_o | output | 1 | All command bits zero |
| short_frame_o | output | 1 | One-cycle pulse: frame had fewer than eight clocks |
| long_frame_o | output | 1 | One-cycle pulse: frame had more than eight clocks |

## Verification
The hardest case to reach is a protection clear that lands in the same system cycle as a commit. The serial edges pass through a synchronizer, so the commit cycle cannot be aimed at directly from the ports. The stimulus handles this by holding a short flag together with overtemperature across the whole frame, which covers the commit cycle whatever the synchronizer delay. It then drops both flags and sends a fresh frame to show that the bit comes back only through a valid write. The bench also checks the shift-register freeze after the eighth clock. This is not visible at the ports on a long frame, so it is covered by a property in the bound checker.

// File: rtl/scr_pkg.sv
package scr_pkg;
   // counter must hold 0 .. WORD_W+1 (saturation value marks a long frame)
   function automatic int cnt_width(input int word_w);
      return $clog2(word_w + 2);
   endfunction

   typedef enum logic [1:0] {
      FRM_OK    = 2'd0,
      FRM_SHORT = 2'd1,
      FRM_LONG  = 2'd2
   } frame_kind_e;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              hist;

   if (STAGES < 2) begin : g_bad_stages
      $error("scr_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= RST_VAL;
      else        hist <= chain[STAGES-1];
   end

   assign q_o    = chain[STAGES-1];
   assign rise_o = chain[STAGES-1] & ~hist;
   assign fall_o = ~chain[STAGES-1] & hist;
endmodule

// File: rtl/scr_frame_ctl.sv
module scr_frame_ctl
   import scr_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int CNT_W  = cnt_width(WORD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_q_i,
   input  logic             sel_fall_i,
   input  logic             sel_rise_i,
   input  logic             sclk_fall_i,
   output logic             shift_en_o,
   output logic             commit_o,
   output logic             short_o,
   output logic             long_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

   logic [CNT_W-1:0] cnt;
   logic             active;
   frame_kind_e      kind;

   assign active = ~sel_q_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (sel_fall_i) begin
         cnt <= '0;
      end else if (active && sclk_fall_i && cnt != SAT) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_comb begin
      if (cnt < FULL)       kind = FRM_SHORT;
      else if (cnt == FULL) kind = FRM_OK;
      else                  kind = FRM_LONG;
   end

   assign shift_en_o = active && sclk_fall_i && !sel_fall_i && (cnt < FULL);
   assign commit_o   = sel_rise_i && (kind == FRM_OK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         short_o <= 1'b0;
         long_o  <= 1'b0;
      end else begin
         short_o <= sel_rise_i && (kind == FRM_SHORT);
         long_o  <= sel_rise_i && (kind == FRM_LONG);
      end
   end

   assign cnt_o = cnt;
endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] sr;

   // LSB first: each new bit enters at the top and moves down
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sr <= '0;
      else if (shift_en_i) sr <= {bit_i, sr[WORD_W-1:1]};
   end

   assign word_o = sr;
endmodule

// File: rtl/scr_cmd_reg.sv
module scr_cmd_reg #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [WORD_W-1:0] short_i,
   input  logic              overtemp_i,
   output logic [WORD_W-1:0] cmd_o
);
   logic [WORD_W-1:0] cmd;

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      logic kill;
      assign kill = short_i[b] & overtemp_i;
      // protection clear beats the host write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cmd[b] <= 1'b0;
         else if (kill)     cmd[b] <= 1'b0;
         else if (commit_i) cmd[b] <= word_i[b];
      end
   end

   assign cmd_o = cmd;
endmodule

// File: rtl/serial_cmd_reg.sv
module serial_cmd_reg
   import scr_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic [WORD_W-1:0] short_i,
   input  logic              overtemp_i,
   output logic [WORD_W-1:0] en_o,
   output logic              standby_o,
   output logic              short_frame_o,
   output logic              long_frame_o
);
   localparam int CNT_W = cnt_width(WORD_W);

   if (WORD_W < 2) begin : g_bad_width
      $error("serial_cmd_reg: WORD_W must be at least 2");
   end

   logic             sel_q, sel_fall, sel_rise;
   logic             sclk_q, sclk_fall, sclk_rise;
   logic             sdat_q, sdat_fall, sdat_rise;
   logic             shift_en, commit_ok;
   logic [CNT_W-1:0] frame_cnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] cmd;

   scr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel (
      .clk(clk), .rst_n(rst_n), .d_i(sel_i),
      .q_o(sel_q), .rise_o(sel_rise), .fall_o(sel_fall));

   scr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
      .clk(clk), .rst_n(rst_n), .d_i(sclk_i),
      .q_o(sclk_q), .rise_o(sclk_rise), .fall_o(sclk_fall));

   scr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdat (
      .clk(clk), .rst_n(rst_n), .d_i(sdat_i),
      .q_o(sdat_q), .rise_o(sdat_rise), .fall_o(sdat_fall));

   scr_frame_ctl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .sel_q_i(sel_q), .sel_fall_i(sel_fall), .sel_rise_i(sel_rise),
      .sclk_fall_i(sclk_fall),
      .shift_en_o(shift_en), .commit_o(commit_ok),
      .short_o(short_frame_o), .long_o(long_frame_o),
      .cnt_o(frame_cnt));

   scr_shifter #(.WORD_W(WORD_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .shift_en_i(shift_en),
      .bit_i(sdat_q), .word_o(shreg));

   scr_cmd_reg #(.WORD_W(WORD_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .commit_i(commit_ok), .word_i(shreg),
      .short_i(short_i), .overtemp_i(overtemp_i), .cmd_o(cmd));

   assign en_o      = cmd;
   assign standby_o = (cmd == '0);
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
   parameter int WORD_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] short_i,
   input logic              overtemp_i,
   input logic [WORD_W-1:0] en_o,
   input logic              short_frame_o,
   input logic              long_frame_o,
   input logic              commit_ok,
   input logic              sel_fall,
   input logic [CNT_W-1:0]  frame_cnt,
   input logic [WORD_W-1:0] shreg
);
   // R3: an enable can only turn on in the cycle after a commit
   p_rise_needs_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_o & ~$past(en_o)) != '0) |-> $past(commit_ok));

   // R4: short-frame flag is a single-cycle pulse
   p_short_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      short_frame_o |=> !short_frame_o);

   // R4: a frame is never both short and long
   p_kinds_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(short_frame_o && long_frame_o));

   // R5: long-frame flag is a single-cycle pulse
   p_long_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      long_frame_o |=> !long_frame_o);

   // R5: the counter never goes past its saturation value
   p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_cnt <= CNT_W'(WORD_W + 1));

   // R5: once eight clocks are in, the shift register holds
   p_shift_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_cnt >= CNT_W'(WORD_W) && !sel_fall) |=> $stable(shreg));

   // R8 / R9: short plus overtemperature leaves the bit off next cycle
   p_kill_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((short_i & {WORD_W{overtemp_i}}) != '0) |=>
      ((en_o & $past(short_i & {WORD_W{overtemp_i}})) == '0));
endmodule

bind serial_cmd_reg scr_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .short_i(short_i), .overtemp_i(overtemp_i),
   .en_o(en_o), .short_frame_o(short_frame_o), .long_frame_o(long_frame_o),
   .commit_ok(commit_ok), .sel_fall(sel_fall), .frame_cnt(frame_cnt),
   .shreg(shreg));

// File: tb/serial_cmd_reg_tb_top.sv
module serial_cmd_reg_tb_top;
   localparam int W    = 8;
   localparam int HALF = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel = 1'b1;
   logic         sclk = 1'b0;
   logic         sdat = 1'b0;
   logic [W-1:0] short_f = '0;
   logic         ot = 1'b0;
   logic [W-1:0] en;
   logic         standby, sfrm, lfrm;

   always #2 clk = ~clk;

   serial_cmd_reg #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdat_i(sdat),
      .short_i(short_f), .overtemp_i(ot), .en_o(en), .standby_o(standby),
      .short_frame_o(sfrm), .long_frame_o(lfrm));

   typedef struct {
      logic [W-1:0] cmd;
      logic         stby;
      int           nshort;
      int           nlong;
      string        tag;
   } item_t;

   item_t        sb_q[$];
   event         chk_ev;
   int           vectors = 0, fails = 0;
   int           seen_short = 0, seen_long = 0;
   logic [W-1:0] exp_cmd = '0;
   int           exp_short = 0, exp_long = 0;
   bit           done = 1'b0;

   always @(negedge clk) begin
      if (sfrm) seen_short++;
      if (lfrm) seen_long++;
   end

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         item_t it;
         @(chk_ev);
         @(negedge clk);
         it = sb_q.pop_front();
         vectors++;
         if (en !== it.cmd) begin
            fails++;
            $display("FAIL %s en: actual %h expected %h", it.tag, en, it.cmd);
         end
         if (standby !== it.stby) begin
            fails++;
            $display("FAIL %s standby: actual %b expected %b", it.tag, standby, it.stby);
         end
         if (seen_short != it.nshort) begin
            fails++;
            $display("FAIL %s short pulses: actual %0d expected %0d", it.tag, seen_short, it.nshort);
         end
         if (seen_long != it.nlong) begin
            fails++;
            $display("FAIL %s long pulses: actual %0d expected %0d", it.tag, seen_long, it.nlong);
         end
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic push_check(input string tag);
      item_t it;
      it.cmd = exp_cmd; it.stby = (exp_cmd == '0);
      it.nshort = exp_short; it.nlong = exp_long; it.tag = tag;
      sb_q.push_back(it);
      ->chk_ev;
      wait_cyc(3);
   endtask

   task automatic serial_clock(input logic b);
      sdat = b;
      wait_cyc(HALF);
      sclk = 1'b1;
      wait_cyc(HALF);
      sclk = 1'b0;
      wait_cyc(HALF);
   endtask

   // driver: sends a frame of n clocks, predicts the result, queues it
   task automatic send_frame(input logic [15:0] bits, input int n,
                             input bit mid_check, input string tag);
      logic [W-1:0] kill;
      sel = 1'b0;
      wait_cyc(HALF);
      for (int k = 0; k < n; k++) serial_clock(bits[k % 16]);
      if (mid_check) begin
         wait_cyc(6);
         push_check({tag, " (R3 before select rises)"});
      end
      sel = 1'b1;
      wait_cyc(10);
      kill = short_f & {W{ot}};
      if (n == W)      exp_cmd = bits[W-1:0] & ~kill;
      else             exp_cmd = exp_cmd & ~kill;
      if (n < W)       exp_short++;
      else if (n > W)  exp_long++;
      push_check(tag);
   endtask

   task automatic set_fault(input logic [W-1:0] s, input logic t, input string tag);
      short_f = s;
      ot = t;
      wait_cyc(4);
      exp_cmd = exp_cmd & ~(s & {W{t}});
      push_check(tag);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      push_check("R1 reset state");

      send_frame(16'h00A5, 8, 1'b1, "R2 R3 frame A5");
      send_frame(16'h0001, 8, 1'b0, "R2 low-side 1 only");
      send_frame(16'h0080, 8, 1'b0, "R2 high-side 4 only");
      send_frame(16'h00FF, 5, 1'b0, "R4 five clocks");
      send_frame(16'h00FF, 0, 1'b0, "R4 no clocks");
      send_frame(16'h0000, 7, 1'b0, "R4 seven clocks");
      send_frame(16'h5A0F, 9, 1'b0, "R5 nine clocks");
      send_frame(16'hFFFF, 13, 1'b0, "R5 thirteen clocks");

      // R6: clocks with select high must not leak into the next frame
      serial_clock(1'b1);
      serial_clock(1'b1);
      serial_clock(1'b0);
      send_frame(16'h003C, 8, 1'b0, "R6 frame after idle clocks");

      send_frame(16'h0000, 8, 1'b0, "R7 all zero gives standby");
      send_frame(16'h00FF, 8, 1'b0, "R7 all ones clears standby");

      set_fault(8'h08, 1'b0, "R8 short alone");
      set_fault(8'h00, 1'b1, "R8 overtemp alone");
      set_fault(8'h08, 1'b1, "R8 short with overtemp");
      set_fault(8'h00, 1'b0, "R10 cleared bit stays off");

      short_f = 8'h40; ot = 1'b1;
      send_frame(16'h00FF, 8, 1'b0, "R9 clear beats commit");
      set_fault(8'h00, 1'b0, "R10 after fault release");
      send_frame(16'h00FF, 8, 1'b0, "R10 valid frame restores");
      send_frame(16'h00C3, 8, 1'b0, "R2 mixed sides");

      wait_cyc(10);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule